// File: doc/BRIEF.md
# Write-Locked Timer Configuration Front End

This block is the register front end of a small timer/counter. A 32-bit register port loads several settings: a main control word (run enable, soft reset, counter width, prescaler and prescaler-sync codes, per-channel capture enables), a per-channel invert mask, a waveform-mode code, an event-selection byte, and a secondary control word (one-shot, count direction).

While the timer is enabled, the configuration settings are locked. Writes to them are dropped without notice. The secondary control word and the enable and soft-reset bits stay writable at all times.

A built-in counter shows the configuration taking effect. Its width comes from the mode code. It counts up or down, wraps at the width's all-ones value, and in one-shot mode it halts after its first wrap. Software that wants to reconfigure a running timer first disables it with one write, then loads the new settings. It may load them and set enable again in a single write.

Top module: `tmr_cfg_top`

## Requirements
- R1: While enabled, writes to the invert (address 1, bits [1:0]), waveform (address 2, bits [1:0]) and event (address 3, bits [7:0]) registers leave their read-back values unchanged. While disabled, those writes take effect at the next clock edge.
- R2: While enabled, a main-control write (address 0) leaves the locked fields unchanged, whatever value enable is written with. If that write has bit 0 clear, enable clears at the same edge.
- R3: While disabled, a main-control write with bit 0 set loads every locked field and sets enable at the same clock edge. The main-control fields are: enable bit 0, soft reset bit 1, mode bits [3:2], prescaler [6:4], prescaler-sync [8:7], capture enables [17:16].
- R4: The mode code selects the counter width: 00 gives 16 bits, 01 gives 8 bits, 10 gives 32 bits, and 11 acts as 16 bits.
- R5: Counting up, the counter advances by one per clock while running and wraps from TOP (all ones for the width) to 0. `wrap_o` is high for exactly the cycle in which the wrapped value appears.
- R6: With direction set (secondary bit 1), an enabling write loads TOP. The counter then decreases by one per clock and wraps from 0 to TOP, raising `wrap_o`.
- R7: With one-shot set (secondary bit 0), the counter halts on its first wrap, holding the wrapped value, and `run_o` drops. A later disable-then-enable restarts it from the start value.
- R8: The secondary control word is writable at any time. Writing to address 4 sets the bits written as 1, writing to address 5 clears the bits written as 1, and 0 bits leave their bits unchanged. Both addresses read back the word.
- R9: A main-control write with bit 1 set returns every register and the counter to reset values at that edge. Bit 1 always reads as 0.
- R10: After reset, every register reads 0 (mode 16-bit, up, not one-shot, disabled), the counter (address 6) reads 0, and `run_o` and `wrap_o` are low.
- R11: An enabling write loads the counter with its start value (0 up, TOP down). The value read at address 6 is the counter masked to the selected width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address (combinational read) |
| rd_data_o | output | 32 | Read data |
| count_o | output | 32 | Counter value masked to width |
| wrap_o | output | 1 | Wrap/overflow pulse |
| run_o | output | 1 | Enabled and not halted |

## Verification
The wrap properties assume no register write occurs in the cycle they observe, because a write could reload, reset or redirect the counter there. They are therefore guarded on an idle write strobe. The bench meets this by issuing no writes during its counting sweeps, so each wrap is seen with an idle port. The lock properties assume a well-formed single-cycle strobe. The bench drives every write for exactly one clock, away from the active edge.

// File: rtl/tmr_cfg_pkg.sv
package tmr_cfg_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned AW   = 3;
  localparam int unsigned NCH  = 2;
  localparam int unsigned PSW  = 3;
  localparam int unsigned PSYW = 2;
  localparam int unsigned WGW  = 2;
  localparam int unsigned EVW  = 8;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_DRV  = 3'd1;
  localparam logic [AW-1:0] A_WAVE = 3'd2;
  localparam logic [AW-1:0] A_EVT  = 3'd3;
  localparam logic [AW-1:0] A_SET  = 3'd4;
  localparam logic [AW-1:0] A_CLR  = 3'd5;
  localparam logic [AW-1:0] A_CNT  = 3'd6;

  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_SRST = 1;
  localparam int unsigned B_MODE = 2;
  localparam int unsigned B_PSC  = 4;
  localparam int unsigned B_PSY  = 7;
  localparam int unsigned B_CAP  = 16;
  localparam int unsigned B_ONE  = 0;
  localparam int unsigned B_DIR  = 1;

  typedef enum logic [1:0] {
    MODE_16  = 2'b00,
    MODE_8   = 2'b01,
    MODE_32  = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  typedef struct packed {
    logic [NCH-1:0]  cap;
    logic [PSYW-1:0] psy;
    logic [PSW-1:0]  psc;
    mode_e           mode;
  } ctrl_t;

  function automatic logic [DW-1:0] top_of(input logic [1:0] m);
    case (m)
      MODE_8:  top_of = 32'h0000_00FF;
      MODE_32: top_of = 32'hFFFF_FFFF;
      default: top_of = 32'h0000_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
  import tmr_cfg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  output logic           en_o,
  output ctrl_t          ctrl_o,
  output mode_e          mode_nx_o,
  output logic [NCH-1:0] inven_o,
  output logic [WGW-1:0] wave_o,
  output logic [EVW-1:0] evt_o,
  output logic           oneshot_o,
  output logic           dir_o,
  output logic           start_o,
  output logic           srst_o
);
  logic           en_q;
  ctrl_t          ctrl_q, ctrl_d;
  logic [NCH-1:0] inven_q;
  logic [WGW-1:0] wave_q;
  logic [EVW-1:0] evt_q;
  logic           one_q, dir_q;
  logic           wr_ctrl, cfg_open;
  logic           unused_wd;

  assign unused_wd = ^wr_data_i;
  assign wr_ctrl   = wr_en_i && (wr_addr_i == A_CTRL);
  assign srst_o    = wr_ctrl && wr_data_i[B_SRST];
  assign cfg_open  = !en_q;
  assign start_o   = wr_ctrl && !srst_o && cfg_open && wr_data_i[B_EN];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl && cfg_open) begin
      ctrl_d.mode = mode_e'(wr_data_i[B_MODE +: 2]);
      ctrl_d.psc  = wr_data_i[B_PSC +: PSW];
      ctrl_d.psy  = wr_data_i[B_PSY +: PSYW];
      ctrl_d.cap  = wr_data_i[B_CAP +: NCH];
    end
  end
  assign mode_nx_o = ctrl_d.mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      ctrl_q  <= '0;
      inven_q <= '0;
      wave_q  <= '0;
      evt_q   <= '0;
      one_q   <= 1'b0;
      dir_q   <= 1'b0;
    end else if (srst_o) begin
      en_q    <= 1'b0;
      ctrl_q  <= '0;
      inven_q <= '0;
      wave_q  <= '0;
      evt_q   <= '0;
      one_q   <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= wr_data_i[B_EN];
      ctrl_q <= ctrl_d;
      if (wr_en_i && cfg_open) begin
        case (wr_addr_i)
          A_DRV:   inven_q <= wr_data_i[NCH-1:0];
          A_WAVE:  wave_q  <= wr_data_i[WGW-1:0];
          A_EVT:   evt_q   <= wr_data_i[EVW-1:0];
          default: ;
        endcase
      end
      // secondary word: never locked
      if (wr_en_i && wr_addr_i == A_SET) begin
        if (wr_data_i[B_ONE]) one_q <= 1'b1;
        if (wr_data_i[B_DIR]) dir_q <= 1'b1;
      end else if (wr_en_i && wr_addr_i == A_CLR) begin
        if (wr_data_i[B_ONE]) one_q <= 1'b0;
        if (wr_data_i[B_DIR]) dir_q <= 1'b0;
      end
    end
  end

  assign en_o      = en_q;
  assign ctrl_o    = ctrl_q;
  assign inven_o   = inven_q;
  assign wave_o    = wave_q;
  assign evt_o     = evt_q;
  assign oneshot_o = one_q;
  assign dir_o     = dir_q;
endmodule

// File: rtl/tmr_cfg_cnt.sv
module tmr_cfg_cnt
  import tmr_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          start_i,
  input  logic          en_i,
  input  mode_e         mode_i,
  input  mode_e         mode_nx_i,
  input  logic          dir_i,
  input  logic          oneshot_i,
  output logic [DW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          halt_o
);
  logic [DW-1:0] cnt_q, cnt_nx, top;
  logic          halt_q, wrap_q, at_end;

  assign top    = top_of(mode_i);
  assign at_end = dir_i ? (cnt_q == '0) : (cnt_q == top);

  always_comb begin
    if (dir_i) cnt_nx = at_end ? top : cnt_q - 1'b1;
    else       cnt_nx = at_end ? '0  : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
      wrap_q <= 1'b0;
    end else if (srst_i) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
      wrap_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= dir_i ? top_of(mode_nx_i) : '0;
      halt_q <= 1'b0;
      wrap_q <= 1'b0;
    end else if (en_i && !halt_q) begin
      cnt_q  <= cnt_nx;
      wrap_q <= at_end;
      if (at_end && oneshot_i) halt_q <= 1'b1;
    end else begin
      wrap_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q & top;
  assign wrap_o = wrap_q;
  assign halt_o = halt_q;
endmodule

// File: rtl/tmr_cfg_top.sv
module tmr_cfg_top
  import tmr_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] count_o,
  output logic          wrap_o,
  output logic          run_o
);
  logic           en, oneshot, dir, start, srst, halt;
  ctrl_t          ctrl;
  mode_e          mode, mode_nx;
  logic [NCH-1:0] inven;
  logic [WGW-1:0] wave;
  logic [EVW-1:0] evt;

  tmr_cfg_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_o(en), .ctrl_o(ctrl), .mode_nx_o(mode_nx), .inven_o(inven),
    .wave_o(wave), .evt_o(evt), .oneshot_o(oneshot), .dir_o(dir),
    .start_o(start), .srst_o(srst)
  );

  assign mode = ctrl.mode;

  tmr_cfg_cnt u_cnt (
    .clk_i, .rst_ni, .srst_i(srst), .start_i(start), .en_i(en),
    .mode_i(mode), .mode_nx_i(mode_nx), .dir_i(dir), .oneshot_i(oneshot),
    .cnt_o(count_o), .wrap_o(wrap_o), .halt_o(halt)
  );

  assign run_o = en && !halt;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CTRL: begin
        rd_data_o[B_EN]           = en;
        rd_data_o[B_MODE +: 2]    = ctrl.mode;
        rd_data_o[B_PSC +: PSW]   = ctrl.psc;
        rd_data_o[B_PSY +: PSYW]  = ctrl.psy;
        rd_data_o[B_CAP +: NCH]   = ctrl.cap;
      end
      A_DRV:  rd_data_o[NCH-1:0] = inven;
      A_WAVE: rd_data_o[WGW-1:0] = wave;
      A_EVT:  rd_data_o[EVW-1:0] = evt;
      A_SET, A_CLR: begin
        rd_data_o[B_ONE] = oneshot;
        rd_data_o[B_DIR] = dir;
      end
      A_CNT:  rd_data_o = count_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_cfg_chk.sv
module tmr_cfg_chk
  import tmr_cfg_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wr_en_i,
  input logic [AW-1:0]  wr_addr_i,
  input logic [DW-1:0]  wr_data_i,
  input logic           en,
  input logic [1:0]     mode,
  input logic           dir,
  input logic           halt,
  input logic [NCH-1:0] inven,
  input logic [DW-1:0]  count_o,
  input logic           wrap_o,
  input logic           run_o
);
  logic wr_ctrl;
  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);

  // R1
  p_drv_locked_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && wr_en_i && wr_addr_i == A_DRV) |=> $stable(inven));

  // R2
  p_ctrl_locked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && wr_ctrl && !wr_data_i[B_SRST]) |=> ($stable(mode) && en == $past(wr_data_i[B_EN])));

  // R3
  p_load_enable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && wr_ctrl && !wr_data_i[B_SRST] && wr_data_i[B_EN])
      |=> (en && mode == $past(wr_data_i[B_MODE +: 2])));

  // R5
  p_up_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !dir && count_o == top_of(mode) && !wr_en_i) |=> (count_o == '0 && wrap_o));

  // R6
  p_dn_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && dir && count_o == '0 && !wr_en_i) |=> (count_o == top_of(mode) && wrap_o));

  // R7
  p_halt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !wr_en_i) |=> ($stable(count_o) && !wrap_o && !run_o));

  // R9
  p_soft_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && wr_data_i[B_SRST]) |=> (!en && count_o == '0 && !run_o));
endmodule

bind tmr_cfg_top tmr_cfg_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .en(en), .mode(mode), .dir(dir), .halt(halt),
  .inven(inven), .count_o(count_o), .wrap_o(wrap_o), .run_o(run_o)
);

// File: tb/tmr_cfg_top_test.sv
`timescale 1ns/1ps
module tmr_cfg_top_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o, count_o;
  logic        wrap_o, run_o;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  tmr_cfg_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .count_o(count_o), .wrap_o(wrap_o), .run_o(run_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  task automatic chk_rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(1);

    // R10 reset state
    chk_rd("R10 ctrl", 3'd0, 32'h0);
    chk_rd("R10 drv", 3'd1, 32'h0);
    chk_rd("R10 wave", 3'd2, 32'h0);
    chk_rd("R10 evt", 3'd3, 32'h0);
    chk_rd("R10 sec", 3'd4, 32'h0);
    chk_rd("R10 cnt", 3'd6, 32'h0);
    chk("R10 run", {31'd0, run_o}, 32'd0);
    chk("R10 wrap", {31'd0, wrap_o}, 32'd0);

    // R1 writes accepted while disabled
    wr(3'd1, 32'h3);
    wr(3'd2, 32'h2);
    wr(3'd3, 32'hA5);
    chk_rd("R1 drv open", 3'd1, 32'h3);
    chk_rd("R1 wave open", 3'd2, 32'h2);
    chk_rd("R1 evt open", 3'd3, 32'hA5);
    // R3 all fields while disabled, soft-reset bit kept 0
    wr(3'd0, 32'h0003_0154);
    chk_rd("R3 fields", 3'd0, 32'h0003_0154);

    // R3 load and enable in one write
    wr(3'd0, 32'h0001_0015);
    chk_rd("R3 load+en", 3'd0, 32'h0001_0015);
    chk("R3 run", {31'd0, run_o}, 32'd1);
    chk("R11 start up", count_o, 32'h0);

    // R1 locked while enabled
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h0);
    chk_rd("R1 drv locked", 3'd1, 32'h3);
    chk_rd("R1 wave locked", 3'd2, 32'h2);
    chk_rd("R1 evt locked", 3'd3, 32'hA5);

    // R2 locked with enable kept
    wr(3'd0, 32'h0000_0079);
    chk_rd("R2 en kept", 3'd0, 32'h0001_0015);
    // R2 clear enable with field change
    wr(3'd0, 32'h0000_0008);
    chk_rd("R2 en clear", 3'd0, 32'h0001_0014);
    chk("R2 run", {31'd0, run_o}, 32'd0);

    // R5 8-bit up sweep
    wr(3'd0, 32'h5);
    chk("R11 8b start", count_o, 32'h0);
    for (int k = 1; k <= 256; k++) begin
      wait_cyc(1);
      chk("R5 8b up cnt", count_o, 32'(k % 256));
      chk("R5 8b up wrap", {31'd0, wrap_o}, (k == 256) ? 32'd1 : 32'd0);
    end
    wr(3'd0, 32'h4);

    // R4 mode 11 acts as 16-bit
    wr(3'd0, 32'hD);
    wait_cyc(300);
    chk("R4 mode11", count_o, 32'd300);
    wr(3'd0, 32'hC);
    // R4 32-bit
    wr(3'd0, 32'h9);
    wait_cyc(300);
    chk("R4 mode32 up", count_o, 32'd300);
    wr(3'd0, 32'h8);
    // R4 R5 16-bit full wrap
    wr(3'd0, 32'h1);
    wait_cyc(65535);
    chk("R4 16b top", count_o, 32'hFFFF);
    chk("R5 16b nowrap", {31'd0, wrap_o}, 32'd0);
    wait_cyc(1);
    chk("R5 16b wrap cnt", count_o, 32'h0);
    chk("R5 16b wrap", {31'd0, wrap_o}, 32'd1);
    wr(3'd0, 32'h0);

    // R8 set direction
    wr(3'd4, 32'h2);
    chk_rd("R8 set dir", 3'd4, 32'h2);
    // R6 8-bit down sweep
    wr(3'd0, 32'h5);
    chk("R6 8b start top", count_o, 32'hFF);
    for (int k = 1; k <= 256; k++) begin
      wait_cyc(1);
      chk("R6 8b dn cnt", count_o, 32'((255 - k + 256) % 256));
      chk("R6 8b dn wrap", {31'd0, wrap_o}, (k == 256) ? 32'd1 : 32'd0);
    end
    wr(3'd0, 32'h4);
    wr(3'd0, 32'h9);
    chk("R6 32b start", count_o, 32'hFFFF_FFFF);
    wait_cyc(5);
    chk("R6 32b dn", count_o, 32'hFFFF_FFFA);
    wr(3'd0, 32'h8);
    wr(3'd0, 32'h1);
    chk("R6 16b start", count_o, 32'hFFFF);
    wait_cyc(3);
    chk("R6 16b dn", count_o, 32'hFFFC);
    wr(3'd0, 32'h0);

    // R8 clear / set / zero bits
    wr(3'd5, 32'h2);
    chk_rd("R8 clr dir", 3'd4, 32'h0);
    wr(3'd4, 32'h1);
    chk_rd("R8 set one", 3'd5, 32'h1);
    wr(3'd4, 32'h0);
    chk_rd("R8 zero set", 3'd4, 32'h1);
    wr(3'd5, 32'h0);
    chk_rd("R8 zero clr", 3'd4, 32'h1);

    // R7 one-shot 8-bit up
    wr(3'd0, 32'h5);
    wait_cyc(255);
    chk("R7 pre", count_o, 32'hFF);
    wait_cyc(1);
    chk("R7 wrap cnt", count_o, 32'h0);
    chk("R7 wrap", {31'd0, wrap_o}, 32'd1);
    chk("R7 halted run", {31'd0, run_o}, 32'd0);
    wait_cyc(20);
    chk("R7 hold", count_o, 32'h0);
    chk("R7 no wrap", {31'd0, wrap_o}, 32'd0);
    wr(3'd0, 32'h4);
    wr(3'd0, 32'h5);
    chk("R7 restart run", {31'd0, run_o}, 32'd1);
    wait_cyc(3);
    chk("R7 restart cnt", count_o, 32'h3);
    // R8 write while enabled
    wr(3'd4, 32'h2);
    chk_rd("R8 set running", 3'd4, 32'h3);

    // R9 soft reset
    wr(3'd1, 32'h1);
    wr(3'd0, 32'h2);
    chk_rd("R9 ctrl", 3'd0, 32'h0);
    chk_rd("R9 drv", 3'd1, 32'h0);
    chk_rd("R9 wave", 3'd2, 32'h0);
    chk_rd("R9 evt", 3'd3, 32'h0);
    chk_rd("R9 sec", 3'd4, 32'h0);
    chk_rd("R9 cnt", 3'd6, 32'h0);
    chk("R9 run", {31'd0, run_o}, 32'd0);
    wr(3'd1, 32'h2);
    chk_rd("R9 unlocked", 3'd1, 32'h2);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule